// File: doc/BRIEF.md
# Interchange Line State Detector

This block watches one received serial data line together with its paired ON/OFF control line. Both are sampled once per bit interval, on a strobe taken from the external signal element timing. From the sampled stream it recognises what the far end is signalling. The recognised conditions are a steady 0, a steady 1, alternating 0/1, a repeating 0011 and a repeating 00001111. Any other stream is treated as unrecognised data. Fault-defaulted lines (data read as 0, control read as OFF) therefore show up as steady 0 with the control OFF, which is the not-ready condition.

A condition becomes the reported one only after a fixed run of contiguous bit intervals. During that run the control level must not change. The report is a class code plus the control level seen when it qualified, a qualified flag, and a one-cycle change pulse. The report holds until a different class or level qualifies. It is also released when the held condition has been absent for more than a fixed number of bit intervals. Character decoding and call sequencing sit elsewhere and use this report as their input.

Top module: `line_state_detector`

## Requirements
- R1: After reset the report is cls_o = 0 (unrecognised), ctl_o = 0, valid_o = 0, chg_o = 0.
- R2: A steady data level qualifies on the 16th contiguous strobe that carries it with an unchanged control level. The code is 1 for steady 0 and 2 for steady 1.
- R3: Alternating data qualifies as code 3 on the 24th consecutive strobe at which the 8 most recent sampled bits equal some rotation of 01010101.
- R4: Repeating 0011 qualifies as code 4 by the same 24-strobe rule, against the rotations of 00110011.
- R5: Repeating 00001111 qualifies as code 5 by the same 24-strobe rule, against the rotations of 00001111.
- R6: A control level that differs from the level at the previous strobe restarts every run counter. The strobe that shows the change counts as zero, so after a level change a steady class needs 17 strobes.
- R7: ctl_o reports the control level at the strobe where the class qualified (1 = ON). The qualification of a different class, or of the same class with a different level, replaces the report.
- R8: chg_o is high for exactly the one clock cycle after the strobe edge that changes the report. A re-qualification of the same class and level gives no pulse.
- R9: The report is released to valid_o = 0, cls_o = 0, with a chg_o pulse, at the 25th consecutive strobe at which the held class does not match or the control level differs from ctl_o. If a class qualifies on that same strobe, the qualification takes effect and no release happens.
- R10: With bit_en low, rx_bit and ctl_in have no effect. Neither the report nor the recorded previous control level changes.
- R11: The 8-bit sample history is cleared by reset, and the pattern comparison includes the bit sampled at the current strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle bit-interval strobe |
| rx_bit | input | 1 | Received data line sample |
| ctl_in | input | 1 | Control/indication level, 1 = ON |
| cls_o | output | 3 | Held class code: 0 none, 1 steady 0, 2 steady 1, 3 alternating, 4 0011, 5 00001111 |
| ctl_o | output | 1 | Control level that came with the held class |
| valid_o | output | 1 | A qualified class is held |
| chg_o | output | 1 | One-cycle pulse when the report changes |

## Verification
Two functions can fall on the same strobe: a new class reaching its threshold, and the release of the held class after its miss run. The bench sets this up with a held steady 0 (control OFF). It then sends nine zeros with the control ON, followed by sixteen ones with the control ON. This makes the miss count reach 25 on the same strobe at which the steady 1 run reaches 16. The expected result is steady 1 with the control ON, valid held high throughout, and exactly one change pulse across the sequence. The behavioural model, compared on every clock, applies the same priority.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    localparam int HIST_W  = 8;
    localparam int NUM_CLS = 5;

    typedef enum logic [2:0] {
        LC_NONE = 3'd0,
        LC_ZERO = 3'd1,
        LC_ONE  = 3'd2,
        LC_ALT  = 3'd3,
        LC_PAIR = 3'd4,
        LC_QUAD = 3'd5
    } line_cls_e;

    typedef struct packed {
        line_cls_e cls;
        logic      ctl;
        logic      valid;
    } lsd_report_t;

    localparam logic [HIST_W-1:0] PAT_ALT  = 8'b0101_0101;
    localparam logic [HIST_W-1:0] PAT_PAIR = 8'b0011_0011;
    localparam logic [HIST_W-1:0] PAT_QUAD = 8'b0000_1111;

    function automatic logic [HIST_W-1:0] rot_left(input logic [HIST_W-1:0] v);
        return {v[HIST_W-2:0], v[HIST_W-1]};
    endfunction

    // True when h equals any rotation of pat (phase-free match)
    function automatic logic any_rotation(input logic [HIST_W-1:0] h,
                                          input logic [HIST_W-1:0] pat);
        logic [HIST_W-1:0] r;
        logic              hit;
        r   = pat;
        hit = 1'b0;
        for (int k = 0; k < HIST_W; k++) begin
            if (h == r) hit = 1'b1;
            r = rot_left(r);
        end
        return hit;
    endfunction

    // Run length needed per class index (index i <-> class code i+1)
    function automatic int run_limit(input int idx, input int steady_len, input int periodic_len);
        return (idx < 2) ? steady_len : periodic_len;
    endfunction

endpackage

// File: rtl/lsd_hist.sv
module lsd_hist
    import lsd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               rx_bit,
    input  logic               ctl_in,
    output logic [NUM_CLS-1:0] match_o,
    output logic               ctl_chg_o
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_nx;
    logic              ctl_prev_q;

    // R11: the comparison includes the current sample
    assign hist_nx = {hist_q[HIST_W-2:0], rx_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q     <= '0;
            ctl_prev_q <= 1'b0;
        end else if (bit_en) begin
            hist_q     <= hist_nx;
            ctl_prev_q <= ctl_in;
        end
    end

    always_comb begin
        match_o[0] = ~rx_bit;
        match_o[1] =  rx_bit;
        match_o[2] = any_rotation(hist_nx, PAT_ALT);
        match_o[3] = any_rotation(hist_nx, PAT_PAIR);
        match_o[4] = any_rotation(hist_nx, PAT_QUAD);
    end

    assign ctl_chg_o = bit_en && (ctl_in != ctl_prev_q);

    // R10: without a strobe the recorded level is frozen
    AST_PREV_CTL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(ctl_prev_q)) else $error("AST_PREV_CTL_FROZEN");   // R10

    // R3: the periodic matches are mutually exclusive
    AST_PERIODIC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_o[4:2])) else $error("AST_PERIODIC_EXCLUSIVE");          // R3

endmodule

// File: rtl/lsd_runcnt.sv
module lsd_runcnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart,
    input  logic match,
    output logic hit
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign hit = en && !restart && match && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (en) begin
            if (restart || !match)
                cnt_q <= '0;                       // R6
            else if (cnt_q != CW'(LIMIT))
                cnt_q <= cnt_q + CW'(1);
        end
    end

    // R2: a run qualifies once, then saturates
    AST_HIT_ONCE: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit) else $error("AST_HIT_ONCE");                              // R2

    // R6: a control change cannot be followed by an immediate qualification
    AST_RESTART_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (en && restart) |=> !hit) else $error("AST_RESTART_NO_HIT");            // R6

endmodule

// File: rtl/lsd_hold.sv
module lsd_hold
    import lsd_pkg::*;
#(
    parameter int REL_LEN = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_en,
    input  logic               ctl_in,
    input  logic [NUM_CLS-1:0] hit_vec,
    input  logic [NUM_CLS-1:0] match_vec,
    output lsd_report_t        rep_o,
    output logic               chg_o
);

    localparam int MW = $clog2(REL_LEN + 1);

    lsd_report_t   rep_q;
    logic          chg_q;
    logic [MW-1:0] miss_q;
    logic          any_hit;
    line_cls_e     hit_cls;
    logic          held_match;
    logic          miss_now;
    logic          differs;

    always_comb begin
        any_hit = 1'b0;
        hit_cls = LC_NONE;
        for (int i = NUM_CLS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                hit_cls = line_cls_e'(i + 1);
            end
        end
    end

    always_comb begin
        held_match = 1'b0;
        for (int i = 0; i < NUM_CLS; i++) begin
            if (rep_q.cls == line_cls_e'(i + 1)) held_match = match_vec[i];
        end
    end

    assign miss_now = rep_q.valid && (!held_match || (ctl_in != rep_q.ctl));
    assign differs  = !rep_q.valid || (hit_cls != rep_q.cls) || (ctl_in != rep_q.ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_q  <= '{cls: LC_NONE, ctl: 1'b0, valid: 1'b0};   // R1
            chg_q  <= 1'b0;
            miss_q <= '0;
        end else begin
            chg_q <= 1'b0;                                      // R8
            if (bit_en) begin
                if (any_hit) begin                              // R7, R9 priority
                    miss_q <= '0;
                    if (differs) begin
                        rep_q <= '{cls: hit_cls, ctl: ctl_in, valid: 1'b1};
                        chg_q <= 1'b1;
                    end
                end else if (miss_now) begin
                    if (miss_q == MW'(REL_LEN)) begin           // R9
                        rep_q  <= '{cls: LC_NONE, ctl: 1'b0, valid: 1'b0};
                        chg_q  <= 1'b1;
                        miss_q <= '0;
                    end else begin
                        miss_q <= miss_q + MW'(1);
                    end
                end else begin
                    miss_q <= '0;
                end
            end
        end
    end

    assign rep_o = rep_q;
    assign chg_o = chg_q;

    AST_CHG_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> !chg_q) else $error("AST_CHG_NEEDS_STROBE");                // R8

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(rep_q)) else $error("AST_QUIET_HOLD");              // R10

    AST_RELEASE_NONE: assert property (@(posedge clk) disable iff (rst)
        $fell(rep_q.valid) |-> (rep_q.cls == LC_NONE) && chg_q)
        else $error("AST_RELEASE_NONE");                                        // R9

endmodule

// File: rtl/line_state_detector.sv
module line_state_detector
    import lsd_pkg::*;
#(
    parameter int STEADY_LEN   = 16,
    parameter int PERIODIC_LEN = 24,
    parameter int REL_LEN      = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       rx_bit,
    input  logic       ctl_in,
    output logic [2:0] cls_o,
    output logic       ctl_o,
    output logic       valid_o,
    output logic       chg_o
);

    logic [NUM_CLS-1:0] match_vec;
    logic [NUM_CLS-1:0] hit_vec;
    logic               ctl_chg;
    lsd_report_t        rep;

    lsd_hist u_hist (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .ctl_in    (ctl_in),
        .match_o   (match_vec),
        .ctl_chg_o (ctl_chg)
    );

    // R2..R5: one run counter per class, steady or periodic limit
    for (genvar g = 0; g < NUM_CLS; g++) begin : g_run
        lsd_runcnt #(
            .LIMIT (run_limit(g, STEADY_LEN, PERIODIC_LEN))
        ) u_run (
            .clk     (clk),
            .rst     (rst),
            .en      (bit_en),
            .restart (ctl_chg),
            .match   (match_vec[g]),
            .hit     (hit_vec[g])
        );
    end

    lsd_hold #(
        .REL_LEN (REL_LEN)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .ctl_in    (ctl_in),
        .hit_vec   (hit_vec),
        .match_vec (match_vec),
        .rep_o     (rep),
        .chg_o     (chg_o)
    );

    assign cls_o   = rep.cls;
    assign ctl_o   = rep.ctl;
    assign valid_o = rep.valid;

    AST_QUAL_FROM_HIT: assert property (@(posedge clk) disable iff (rst)
        (chg_o && valid_o) |-> $past(|hit_vec)) else $error("AST_QUAL_FROM_HIT"); // R7

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec)) else $error("AST_ONE_HIT");                           // R4

    AST_CLS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (cls_o != 3'd0) && (cls_o <= 3'd5)) else $error("AST_CLS_LEGAL"); // R5

endmodule

// File: tb/line_state_detector_tb.sv
module line_state_detector_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic       ctl_in = 1'b0;
    logic [2:0] cls_o;
    logic       ctl_o, valid_o, chg_o;

    int    total = 0;
    int    bad = 0;
    int    nchg = 0;
    bit    done = 0;
    string phase = "R1";

    line_state_detector u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .ctl_in(ctl_in),
        .cls_o(cls_o), .ctl_o(ctl_o), .valid_o(valid_o), .chg_o(chg_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    int   m_hist[$];
    int   m_run[5];
    int   m_prev_ctl, m_cls, m_ctl, m_valid, m_chg, m_miss;
    int   pats[3] = '{8'h55, 8'h33, 8'h0F};

    function automatic bit rot_hit(int h, int p);
        int r = p;
        for (int k = 0; k < 8; k++) begin
            if (h == r) return 1;
            r = ((r << 1) | (r >> 7)) & 8'hFF;
        end
        return 0;
    endfunction

    task automatic model_reset();
        m_hist = {0,0,0,0,0,0,0,0};
        foreach (m_run[i]) m_run[i] = 0;
        m_prev_ctl = 0; m_cls = 0; m_ctl = 0; m_valid = 0; m_chg = 0; m_miss = 0;
    endtask

    task automatic model_step();
        int  h, lim, hitc;
        bit  mt[5];
        bit  cchg, mmiss;
        m_chg = 0;
        if (!bit_en) return;
        m_hist.push_front(int'(rx_bit));
        void'(m_hist.pop_back());
        h = 0;
        for (int k = 0; k < 8; k++) h = h | (m_hist[k] << k);
        mt[0] = (rx_bit == 0);
        mt[1] = (rx_bit == 1);
        for (int k = 0; k < 3; k++) mt[k+2] = rot_hit(h, pats[k]);
        cchg = (int'(ctl_in) != m_prev_ctl);
        hitc = 0;
        for (int k = 0; k < 5; k++) begin
            lim = (k < 2) ? 16 : 24;
            if (cchg || !mt[k]) m_run[k] = 0;
            else if (m_run[k] < lim) begin
                m_run[k]++;
                if (m_run[k] == lim) hitc = k + 1;
            end
        end
        m_prev_ctl = int'(ctl_in);
        mmiss = m_valid && (!mt[m_cls-1 < 0 ? 0 : m_cls-1] || int'(ctl_in) != m_ctl);
        if (hitc != 0) begin
            m_miss = 0;
            if (!m_valid || hitc != m_cls || int'(ctl_in) != m_ctl) begin
                m_cls = hitc; m_ctl = int'(ctl_in); m_valid = 1; m_chg = 1;
            end
        end else if (mmiss) begin
            if (m_miss == 24) begin
                m_cls = 0; m_ctl = 0; m_valid = 0; m_chg = 1; m_miss = 0;
            end else m_miss++;
        end else m_miss = 0;
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else model_step();
    end

    // ---------------- checking ----------------
    task automatic check(string req, int got, int exp, string what);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(phase, int'(cls_o),   m_cls,   "model cls_o");
            check(phase, int'(ctl_o),   m_ctl,   "model ctl_o");
            check(phase, int'(valid_o), m_valid, "model valid_o");
            check(phase, int'(chg_o),   m_chg,   "model chg_o");
        end
        if (chg_o) nchg++;
    end

    task automatic strobe(input logic b, input logic c);
        @(negedge clk);
        rx_bit = b; ctl_in = c; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        #1;
    endtask

    task automatic send_pat(input logic [7:0] p, input int plen, input int n, input logic c);
        for (int i = 0; i < n; i++) strobe(p[i % plen], c);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        int c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        phase = "R1";
        check("R1", int'(cls_o), 0, "reset cls_o");
        check("R1", int'(valid_o), 0, "reset valid_o");
        check("R1", int'(ctl_o), 0, "reset ctl_o");
        check("R1", int'(chg_o), 0, "reset chg_o");

        phase = "R2";
        send_pat(8'h00, 1, 15, 1'b0);
        check("R2", int'(valid_o), 0, "15 zeros not yet qualified");
        strobe(1'b0, 1'b0);
        check("R2", int'(cls_o), 1, "steady 0 at 16th strobe");
        check("R2", int'(chg_o), 1, "pulse on qualification");
        send_pat(8'h00, 1, 4, 1'b0);

        phase = "R6";
        send_pat(8'h00, 1, 16, 1'b1);
        check("R6", int'(ctl_o), 0, "16 strobes after level change not enough");
        strobe(1'b0, 1'b1);
        check("R6", int'(ctl_o), 1, "requalified with ON at 17th");
        check("R7", int'(cls_o), 1, "class kept, level replaced");

        phase = "R3";
        send_pat(8'h02, 2, 40, 1'b0);
        check("R3", int'(cls_o), 3, "alternating class");
        phase = "R4";
        send_pat(8'h0C, 4, 40, 1'b0);
        check("R4", int'(cls_o), 4, "0011 class");
        phase = "R5";
        send_pat(8'hF0, 8, 48, 1'b0);
        check("R5", int'(cls_o), 5, "00001111 class");
        check("R11", int'(valid_o), 1, "window includes current bit");

        phase = "R8";
        c0 = nchg;
        send_pat(8'hFF, 1, 20, 1'b0);
        strobe(1'b0, 1'b0);
        send_pat(8'hFF, 1, 20, 1'b0);
        check("R8", int'(cls_o), 2, "steady 1 held");
        check("R8", nchg - c0, 1, "no pulse on same re-qualification");

        phase = "R10";
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rx_bit = i[0]; ctl_in = ~i[0];
        end
        @(negedge clk); #1;
        check("R10", int'(cls_o), 2, "ignored without strobe cls_o");
        check("R10", int'(ctl_o), 0, "ignored without strobe ctl_o");
        check("R10", int'(valid_o), 1, "ignored without strobe valid_o");

        phase = "R9";
        send_pat(8'h02, 2, 40, 1'b0);
        check("R9", int'(cls_o), 3, "alternating held before junk");
        send_pat(8'h03, 3, 30, 1'b0);
        check("R9", int'(valid_o), 0, "released after miss run");
        check("R9", int'(cls_o), 0, "released class code");

        phase = "R9";
        send_pat(8'h00, 1, 20, 1'b0);
        check("R2", int'(cls_o), 1, "steady 0 again");
        c0 = nchg;
        send_pat(8'h00, 1, 9, 1'b1);
        send_pat(8'hFF, 1, 15, 1'b1);
        check("R9", int'(valid_o), 1, "still held before coincidence");
        strobe(1'b1, 1'b1);
        check("R9", int'(cls_o), 2, "qualification wins over release");
        check("R9", int'(ctl_o), 1, "level taken on coincidence");
        check("R9", int'(valid_o), 1, "no release on coincidence");
        check("R9", nchg - c0, 1, "single pulse on coincidence");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule